// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block works out the register updates that a 32-bit RISC core needs when it takes an exception, and the updates it needs when it leaves an exception handler. There is one request line for each source: reset, undefined instruction, software interrupt, prefetch abort, data abort, IRQ and FIQ. When several lines are active at once, a fixed priority picks one winner. For the winner, the block produces four values: the copy of the status word to store in the saved status register, the new status word, the value for the link register, and the vector address to load into the PC.

A separate return strobe asks for the status word to be restored from the saved copy and for the PC to be reloaded from the link register, both as one update. All results are registered. They appear one clock after the edge that samples the request, together with a one-cycle valid pulse. Decoding instructions, holding the banked registers and flushing the pipeline are left to the core around this block.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The vector address is the table base plus 4 times the source slot: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C. Slot 0x14 is never produced.
- R2: With `hi_vec` low the table base is 0x00000000. With `hi_vec` high it is the parameter `HI_BASE` (default 0xFFFF0000).
- R3: On entry, `spsr_wr` equals the sampled `cur_psr` and `lr_wr` equals the sampled `cur_pc`.
- R4: On entry, `psr_nxt` holds the target mode in bits 4:0, has bit 5 (T) cleared and bit 7 (I) set, and keeps every other bit of `cur_psr`, including N/Z/C/V in bits 31:28 and Q in bit 27.
- R5: Bit 6 (F) of `psr_nxt` is set on reset and FIQ entry. On any other entry it is copied from `cur_psr`.
- R6: The target mode, also driven on `tgt_mode`, is 10011 for reset and software interrupt, 11011 for undefined, 10111 for either abort, 10010 for IRQ and 10001 for FIQ.
- R7: A return strobe with no accepted exception gives `ret_vld`, with `psr_nxt` equal to `saved_psr` and `pc_nxt` equal to `saved_lr`.
- R8: `req_irq` has no effect while bit 7 of `cur_psr` is set. `req_fiq` has no effect while bit 6 is set.
- R9: Priority from highest to lowest is reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt. Any accepted exception wins over a return strobe in the same cycle.
- R10: `ent_vld` and `ret_vld` are low in reset. They rise exactly one clock after the edge that samples an accepted request, and they are low after a cycle that has none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rst | input | 1 | Reset exception request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | IRQ request |
| req_fiq | input | 1 | FIQ request |
| ret_req | input | 1 | Exception return strobe |
| hi_vec | input | 1 | Selects the high vector table base |
| cur_psr | input | XLEN | Current status word |
| cur_pc | input | XLEN | Return address to be saved |
| saved_psr | input | XLEN | Saved status word of the current mode |
| saved_lr | input | XLEN | Link register of the current mode |
| ent_vld | output | 1 | Entry results valid |
| ret_vld | output | 1 | Return results valid |
| tgt_mode | output | 5 | Mode entered |
| spsr_wr | output | XLEN | Value for the saved status register |
| psr_nxt | output | XLEN | New status word |
| lr_wr | output | XLEN | Value for the link register |
| pc_nxt | output | XLEN | New PC |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath and a high table base of 0xFFFF0000. Both settings of `hi_vec` are driven, so both vector bases are tested at their full width. Because the status word is 32 bits wide, the tests can place patterns in the flag bits and the Q bit and check that entry leaves them unchanged while it rewrites the mode, T, I and F fields. The requests are applied singly, in competing pairs, and against masked interrupt states, which covers every priority step and both disable bits.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int MODE_W = 5;
  localparam int NSLOT  = 8;
  localparam int SLOT_W = $clog2(NSLOT);

  // slot numbers equal vector offset / 4
  localparam logic [SLOT_W-1:0] SLOT_RST  = 3'd0;
  localparam logic [SLOT_W-1:0] SLOT_UND  = 3'd1;
  localparam logic [SLOT_W-1:0] SLOT_SWI  = 3'd2;
  localparam logic [SLOT_W-1:0] SLOT_PABT = 3'd3;
  localparam logic [SLOT_W-1:0] SLOT_DABT = 3'd4;
  localparam logic [SLOT_W-1:0] SLOT_RSVD = 3'd5;
  localparam logic [SLOT_W-1:0] SLOT_IRQ  = 3'd6;
  localparam logic [SLOT_W-1:0] SLOT_FIQ  = 3'd7;

  // index 0 is the highest priority
  localparam logic [SLOT_W-1:0] PRIO [NSLOT] = '{
    SLOT_RST, SLOT_DABT, SLOT_FIQ, SLOT_IRQ,
    SLOT_PABT, SLOT_UND, SLOT_SWI, SLOT_RSVD};

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  // status word bit positions
  localparam int BIT_T = 5;
  localparam int BIT_F = 6;
  localparam int BIT_I = 7;

  function automatic logic [MODE_W-1:0] slot_mode(input logic [SLOT_W-1:0] s);
    case (s)
      SLOT_UND:             slot_mode = MODE_UND;
      SLOT_PABT, SLOT_DABT: slot_mode = MODE_ABT;
      SLOT_IRQ:             slot_mode = MODE_IRQ;
      SLOT_FIQ:             slot_mode = MODE_FIQ;
      default:              slot_mode = MODE_SVC;
    endcase
  endfunction
endpackage

// File: rtl/exc_arb.sv
module exc_arb
  import exc_pkg::*;
(
  input  logic [NSLOT-1:0]  req,
  input  logic              irq_dis,
  input  logic              fiq_dis,
  output logic              hit,
  output logic [SLOT_W-1:0] win
);
  logic [NSLOT-1:0] eff;

  always_comb begin
    eff            = req;
    eff[SLOT_IRQ]  = req[SLOT_IRQ] & ~irq_dis;
    eff[SLOT_FIQ]  = req[SLOT_FIQ] & ~fiq_dis;
    eff[SLOT_RSVD] = 1'b0;
    hit = |eff;
    win = SLOT_RST;
    // walk from lowest to highest priority; the last hit wins
    for (int k = NSLOT - 1; k >= 0; k--) begin
      if (eff[PRIO[k]]) win = PRIO[k];
    end
  end
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter logic [XLEN-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic [SLOT_W-1:0] win,
  input  logic              hi_vec,
  input  logic [XLEN-1:0]   cur_psr,
  output logic [MODE_W-1:0] mode,
  output logic [XLEN-1:0]   psr_new,
  output logic [XLEN-1:0]   vec
);
  localparam int OFS_LSB = 2;

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] ofs;

  always_comb begin
    mode = slot_mode(win);
    base = hi_vec ? HI_BASE : '0;
    ofs  = '0;
    ofs[OFS_LSB +: SLOT_W] = win;
    vec  = base + ofs;

    psr_new               = cur_psr;
    psr_new[MODE_W-1:0]   = mode;
    psr_new[BIT_T]        = 1'b0;
    psr_new[BIT_I]        = 1'b1;
    if (win == SLOT_RST || win == SLOT_FIQ) psr_new[BIT_F] = 1'b1;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter logic [XLEN-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rst,
  input  logic              req_und,
  input  logic              req_swi,
  input  logic              req_pabt,
  input  logic              req_dabt,
  input  logic              req_irq,
  input  logic              req_fiq,
  input  logic              ret_req,
  input  logic              hi_vec,
  input  logic [XLEN-1:0]   cur_psr,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   saved_psr,
  input  logic [XLEN-1:0]   saved_lr,
  output logic              ent_vld,
  output logic              ret_vld,
  output logic [MODE_W-1:0] tgt_mode,
  output logic [XLEN-1:0]   spsr_wr,
  output logic [XLEN-1:0]   psr_nxt,
  output logic [XLEN-1:0]   lr_wr,
  output logic [XLEN-1:0]   pc_nxt
);
  logic [NSLOT-1:0]  req_vec;
  logic              hit;
  logic [SLOT_W-1:0] win;
  logic [MODE_W-1:0] calc_mode;
  logic [XLEN-1:0]   calc_psr;
  logic [XLEN-1:0]   calc_vec;

  always_comb begin
    req_vec            = '0;
    req_vec[SLOT_RST]  = req_rst;
    req_vec[SLOT_UND]  = req_und;
    req_vec[SLOT_SWI]  = req_swi;
    req_vec[SLOT_PABT] = req_pabt;
    req_vec[SLOT_DABT] = req_dabt;
    req_vec[SLOT_IRQ]  = req_irq;
    req_vec[SLOT_FIQ]  = req_fiq;
  end

  exc_arb u_arb (
    .req     (req_vec),
    .irq_dis (cur_psr[BIT_I]),
    .fiq_dis (cur_psr[BIT_F]),
    .hit     (hit),
    .win     (win)
  );

  exc_entry_calc #(.XLEN(XLEN), .HI_BASE(HI_BASE)) u_calc (
    .win     (win),
    .hi_vec  (hi_vec),
    .cur_psr (cur_psr),
    .mode    (calc_mode),
    .psr_new (calc_psr),
    .vec     (calc_vec)
  );

  // next-state
  logic              ent_d, ret_d, ld_en;
  logic [MODE_W-1:0] mode_d;
  logic [XLEN-1:0]   spsr_d, psr_d, lr_d, pc_d;

  always_comb begin
    ent_d  = hit;
    ret_d  = ret_req & ~hit;
    ld_en  = ent_d | ret_d;
    mode_d = calc_mode;
    spsr_d = cur_psr;
    lr_d   = cur_pc;
    psr_d  = hit ? calc_psr : saved_psr;
    pc_d   = hit ? calc_vec : saved_lr;
    if (!hit) mode_d = saved_psr[MODE_W-1:0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld <= 1'b0;
      ret_vld <= 1'b0;
    end else begin
      ent_vld <= ent_d;
      ret_vld <= ret_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_mode <= MODE_SVC;
      spsr_wr  <= '0;
      psr_nxt  <= '0;
      lr_wr    <= '0;
      pc_nxt   <= '0;
    end else if (ld_en) begin
      tgt_mode <= mode_d;
      spsr_wr  <= spsr_d;
      psr_nxt  <= psr_d;
      lr_wr    <= lr_d;
      pc_nxt   <= pc_d;
    end
  end

  // checks
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ent_vld && ret_vld));
  p_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ent_vld |-> (pc_nxt[1:0] == 2'b00 && pc_nxt[4:2] != 3'd5));
  p_state_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ent_vld |-> (!psr_nxt[BIT_T] && psr_nxt[BIT_I] && psr_nxt[MODE_W-1:0] == tgt_mode));
  p_spsr_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ent_d |=> (spsr_wr == $past(cur_psr) && lr_wr == $past(cur_pc)));
  p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_d && win == SLOT_IRQ) |-> !cur_psr[BIT_I]);
  p_fiq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_d && win == SLOT_FIQ) |-> !cur_psr[BIT_F]);
  p_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_d |=> (ret_vld && psr_nxt == $past(saved_psr) && pc_nxt == $past(saved_lr)));
  p_reset_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_rst |=> (ent_vld && tgt_mode == MODE_SVC && pc_nxt[4:0] == 5'd0));
endmodule

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic req_rst, req_und, req_swi, req_pabt, req_dabt, req_irq, req_fiq;
  logic ret_req, hi_vec;
  logic [31:0] cur_psr, cur_pc, saved_psr, saved_lr;
  logic ent_vld, ret_vld;
  logic [4:0] tgt_mode;
  logic [31:0] spsr_wr, psr_nxt, lr_wr, pc_nxt;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  exc_entry_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .req_rst(req_rst), .req_und(req_und), .req_swi(req_swi),
    .req_pabt(req_pabt), .req_dabt(req_dabt), .req_irq(req_irq),
    .req_fiq(req_fiq), .ret_req(ret_req), .hi_vec(hi_vec),
    .cur_psr(cur_psr), .cur_pc(cur_pc), .saved_psr(saved_psr),
    .saved_lr(saved_lr), .ent_vld(ent_vld), .ret_vld(ret_vld),
    .tgt_mode(tgt_mode), .spsr_wr(spsr_wr), .psr_nxt(psr_nxt),
    .lr_wr(lr_wr), .pc_nxt(pc_nxt));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // source codes for the bench: 0 rst,1 und,2 swi,3 pabt,4 dabt,6 irq,7 fiq
  function automatic logic [4:0] exp_mode(input int s);
    case (s)
      0, 2:    return 5'b10011;
      1:       return 5'b11011;
      3, 4:    return 5'b10111;
      6:       return 5'b10010;
      default: return 5'b10001;
    endcase
  endfunction

  function automatic logic [31:0] exp_vec(input int s, input logic hv);
    return (hv ? 32'hFFFF_0000 : 32'h0) + 32'(s * 4);
  endfunction

  function automatic logic [31:0] exp_psr(input int s, input logic [31:0] p);
    logic [31:0] r = p;
    r[4:0] = exp_mode(s);
    r[5] = 1'b0;
    r[7] = 1'b1;
    if (s == 0 || s == 7) r[6] = 1'b1;
    return r;
  endfunction

  task automatic idle();
    {req_rst, req_und, req_swi, req_pabt, req_dabt, req_irq, req_fiq, ret_req} = '0;
  endtask

  task automatic raise(input int s);
    case (s)
      0: req_rst = 1'b1;
      1: req_und = 1'b1;
      2: req_swi = 1'b1;
      3: req_pabt = 1'b1;
      4: req_dabt = 1'b1;
      6: req_irq = 1'b1;
      default: req_fiq = 1'b1;
    endcase
  endtask

  // called at a negedge with inputs set; returns at the next negedge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic expect_entry(input string tag, input int s, input logic [31:0] p,
                              input logic [31:0] pc, input logic hv);
    chk({tag, " ent_vld"}, 32'(ent_vld), 32'd1);
    chk({tag, " ret_vld"}, 32'(ret_vld), 32'd0);
    chk({tag, " mode"}, 32'(tgt_mode), 32'(exp_mode(s)));
    chk({tag, " pc"}, pc_nxt, exp_vec(s, hv));
    chk({tag, " psr"}, psr_nxt, exp_psr(s, p));
    chk({tag, " spsr"}, spsr_wr, p);
    chk({tag, " lr"}, lr_wr, pc);
  endtask

  task automatic t_reset();
    chk("R10 reset ent_vld", 32'(ent_vld), 32'd0);
    chk("R10 reset ret_vld", 32'(ret_vld), 32'd0);
  endtask

  // R1 R3 R4 R5 R6: each source alone, low vectors, flags and Q set
  task automatic t_each_source();
    int srcs[7] = '{0, 1, 2, 3, 4, 6, 7};
    foreach (srcs[i]) begin
      idle();
      hi_vec  = 1'b0;
      cur_psr = 32'hF800_0010;
      cur_pc  = 32'h0000_1000 + 32'(i * 16);
      raise(srcs[i]);
      step();
      expect_entry($sformatf("R1 R3 R4 R5 R6 src%0d", srcs[i]), srcs[i],
                   32'hF800_0010, 32'h0000_1000 + 32'(i * 16), 1'b0);
    end
    idle();
    step();
    chk("R10 no request ent_vld", 32'(ent_vld), 32'd0);
  endtask

  // R5: F copied when not reset/FIQ, with T set on input
  task automatic t_f_keep();
    idle();
    cur_psr = 32'h5000_0030;
    cur_pc  = 32'h0000_2000;
    req_dabt = 1'b1;
    step();
    chk("R5 F held clear", 32'(psr_nxt[6]), 32'd0);
    chk("R4 T cleared", 32'(psr_nxt[5]), 32'd0);
    idle();
    cur_psr = 32'h0000_0050;
    req_swi = 1'b1;
    step();
    chk("R5 F held set", 32'(psr_nxt[6]), 32'd1);
  endtask

  // R2: high vectors
  task automatic t_hivec();
    int srcs[3] = '{0, 4, 7};
    foreach (srcs[i]) begin
      idle();
      hi_vec  = 1'b1;
      cur_psr = 32'h2000_0010;
      cur_pc  = 32'h0000_3000;
      raise(srcs[i]);
      step();
      expect_entry($sformatf("R2 hi src%0d", srcs[i]), srcs[i],
                   32'h2000_0010, 32'h0000_3000, 1'b1);
    end
    hi_vec = 1'b0;
  endtask

  // R9: priority chain, each pair top vs next
  task automatic t_priority();
    int order[7] = '{0, 4, 7, 6, 3, 1, 2};
    for (int k = 0; k < 6; k++) begin
      idle();
      cur_psr = 32'h0000_0010;
      cur_pc  = 32'h0000_4000;
      for (int j = k; j < 7; j++) raise(order[j]);
      step();
      chk($sformatf("R9 prio win%0d pc", order[k]), pc_nxt, exp_vec(order[k], 1'b0));
      chk($sformatf("R9 prio win%0d mode", order[k]), 32'(tgt_mode), 32'(exp_mode(order[k])));
    end
  endtask

  // R8: masked interrupts
  task automatic t_mask();
    idle();
    cur_psr = 32'h0000_0090; // I set
    req_irq = 1'b1;
    step();
    chk("R8 irq masked ent_vld", 32'(ent_vld), 32'd0);
    idle();
    cur_psr = 32'h0000_0050; // F set
    req_fiq = 1'b1;
    req_pabt = 1'b1;
    step();
    chk("R8 fiq masked, pabt taken", pc_nxt, 32'h0000_000C);
    idle();
    cur_psr = 32'h0000_0050; // F set, I clear
    req_fiq = 1'b1;
    req_irq = 1'b1;
    step();
    chk("R8 fiq masked, irq taken", pc_nxt, 32'h0000_0018);
    idle();
    cur_psr = 32'h0000_0090; // I set: masked irq lets return through
    saved_psr = 32'h8000_0010;
    saved_lr  = 32'h0000_ABC0;
    req_irq = 1'b1;
    ret_req = 1'b1;
    step();
    chk("R8 masked irq ret_vld", 32'(ret_vld), 32'd1);
    chk("R8 masked irq ent_vld", 32'(ent_vld), 32'd0);
  endtask

  // R7: return restores
  task automatic t_return();
    idle();
    cur_psr   = 32'h0000_0092;
    saved_psr = 32'h6000_0030;
    saved_lr  = 32'h1234_5678;
    ret_req   = 1'b1;
    step();
    chk("R7 ret_vld", 32'(ret_vld), 32'd1);
    chk("R7 psr", psr_nxt, 32'h6000_0030);
    chk("R7 pc", pc_nxt, 32'h1234_5678);
    idle();
    step();
    chk("R10 ret pulse ends", 32'(ret_vld), 32'd0);
  endtask

  // R9: exception beats return
  task automatic t_entry_over_return();
    idle();
    cur_psr   = 32'h0000_0010;
    cur_pc    = 32'h0000_5000;
    saved_psr = 32'h0000_0013;
    saved_lr  = 32'h0000_9990;
    ret_req   = 1'b1;
    req_und   = 1'b1;
    step();
    chk("R9 entry over return ent", 32'(ent_vld), 32'd1);
    chk("R9 entry over return ret", 32'(ret_vld), 32'd0);
    chk("R9 entry over return pc", pc_nxt, 32'h0000_0004);
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    hi_vec = 1'b0;
    cur_psr = '0; cur_pc = '0; saved_psr = '0; saved_lr = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_each_source();
    t_f_keep();
    t_hivec();
    t_priority();
    t_mask();
    t_return();
    t_entry_over_return();
    idle();
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule